// File: doc/BRIEF.md
# Seeded Mixing Random Generator

The block keeps a 1024-bit seed in an internal array of 32 words of 32 bits. Software or a host loads the seed over one 64-bit data path, with one write strobe for each 64-bit transfer. When the start request is seen, the block runs 256 feedback steps. Each step mixes one stored word into two 32-bit accumulators, `a` and `b`, and writes a scrambled word back into the array. When the run is over, the block presents a 64-bit pseudorandom result, one chunk per read request.

The datapath has two pipeline stages, and each stage takes five clock cycles. Stage one updates `a` and captures the operands that stage two needs. Stage two updates `b` and writes the mixed word back. The two stages overlap, so a run lasts 257 stage periods. The port is bidirectional in style: the input data bus is separate from a registered output bus, and a drive-enable strobe marks each valid output beat. The same seed always gives the same result. The array is not cleared by reset, so a later run without a reload continues from the mixed contents.

Top module: `seeded_mixer_rng`

## Requirements
- R1: While reset is asserted and directly after it is released, ready is 1, done is 0 and dataOutEn is 0. Reset clears the accumulators, the step counter, the pipeline and the load pointer.
- R2: In a cycle where ready is high, wrStrobe is high and no run is starting, dataIn[31:0] is written to word 2p and dataIn[63:32] to word 2p+1. Here p is a load pointer in the range 0 to 15. The pointer then advances, and from 15 it wraps to 0. Reset returns it to 0, and so does the start of a run.
- R3: A run starts when genReq is high in a cycle where it was low in the previous cycle and ready is high. From the next cycle on, ready is low. A genReq held high starts nothing further, and ready stays high while no new rising level is seen.
- R4: A run lasts 257 periods of 5 cycles. done is high for exactly one cycle, 1285 cycles after the first cycle in which ready is low. ready is low while done is high, and it is high again in the cycle after done.
- R5: At the start of a run, a = 0x6A09E667 and b = 0xBB67AE85. For each step s from 0 to 255, with i = s mod 32, the block computes a = a + rotl(a,13) + w[i], then b = b + a + w[(i+1) mod 32], then w[i] = a XOR b.
- R6: After a completed run, a cycle with rdReq high while ready is high (and no run starting) loads dataOut and raises dataOutEn for the next cycle. The chunks alternate. Chunk 0 is {a in [63:32], b in [31:0]}. Chunk 1 is {a XOR b in [63:32], a + b in [31:0]}. The first read after each run returns chunk 0.
- R7: Reads are ignored, and dataOutEn stays low, before the first completed run after reset and whenever ready is low.
- R8: wrStrobe and rising genReq levels during a run have no effect. The array keeps its contents and the run is not restarted.
- R9: Reset leaves the seed array untouched. A run after reset without a reload mixes the contents left by the previous run.
- R10: Loading the same seed again gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Write one 64-bit seed transfer |
| genReq | input | 1 | Start request, acts on a rising level |
| rdReq | input | 1 | Request the next result chunk |
| dataIn | input | 64 | Seed data in |
| dataOut | output | 64 | Result chunk out, registered |
| dataOutEn | output | 1 | Output drive enable, high for one cycle per read |
| ready | output | 1 | Idle: accepts seed, start and read |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The checker watches the control handshake on every cycle:
- that a start drops ready,
- that ready holds while there is no start,
- that done is a single pulse followed by ready,
- that the run length is exact,
- that output beats only appear while the block is idle.

Some behaviours can only be shown by bench scenarios run against a software model of the mixing step. These are the numerical result, the load-pointer wrap and reset, the order of the chunks, and the fact that writes during a run are ignored. The same holds for survival of the array across reset and for the repeat of a result from the same seed.

// File: rtl/rng_pkg.sv
package rng_pkg;

  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadWr;   // store one seed transfer at the load pointer
    logic runInit;  // a run begins: preset accumulators, clear pipe
    logic beat;     // last cycle of a stage period: both stages advance
    logic issue;    // stage one accepts a new step on this beat
    logic rdTake;   // present the next result chunk
  } rngStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rngState_t;

endpackage

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int ITERS        = 256,
  parameter int STAGE_CYCLES = 5,
  parameter int WORDS        = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     genReq,
  input  logic                     rdReq,
  input  logic                     wrStrobe,
  output logic                     ready,
  output logic                     done,
  output rngStrobes_t              strb,
  output logic [$clog2(WORDS)-1:0] stepIdx
);

  localparam int ADDR_W = $clog2(WORDS);
  localparam int PH_W   = $clog2(STAGE_CYCLES + 1);
  localparam int IT_W   = $clog2(ITERS + 1);

  rngState_t          state;
  logic [PH_W-1:0]    phase;
  logic [IT_W-1:0]    issueCnt;
  logic               genPrev;
  logic               resultValid;

  logic startEv;
  logic beatNow;
  logic issueNow;

  assign startEv  = (state == ST_IDLE) && genReq && !genPrev;
  assign beatNow  = (state == ST_RUN) && (phase == PH_W'(STAGE_CYCLES - 1));
  assign issueNow = beatNow && (issueCnt < IT_W'(ITERS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      phase       <= '0;
      issueCnt    <= '0;
      genPrev     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      genPrev <= genReq;
      case (state)
        ST_IDLE: begin
          if (startEv) begin
            state       <= ST_RUN;
            phase       <= '0;
            issueCnt    <= '0;
            resultValid <= 1'b0;
          end
        end
        ST_RUN: begin
          if (beatNow) begin
            phase <= '0;
            if (issueNow) begin
              issueCnt <= issueCnt + IT_W'(1);
            end else begin
              // drain beat: stage two retires the last step
              state <= ST_DONE;
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_DONE: begin
          state       <= ST_IDLE;
          resultValid <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready = (state == ST_IDLE);
  assign done  = (state == ST_DONE);

  assign strb.loadWr  = ready && wrStrobe && !startEv;
  assign strb.runInit = startEv;
  assign strb.beat    = beatNow;
  assign strb.issue   = issueNow;
  assign strb.rdTake  = ready && resultValid && rdReq && !startEv;

  assign stepIdx = ADDR_W'(issueCnt % IT_W'(WORDS));

endmodule

// File: rtl/rng_datapath.sv
module rng_datapath
  import rng_pkg::*;
#(
  parameter int              WORDS  = 32,
  parameter int              WORD_W = 32,
  parameter int              DATA_W = 64,
  parameter int              ROT    = 13,
  parameter logic [WORD_W-1:0] A_INIT = 32'h6A09E667,
  parameter logic [WORD_W-1:0] B_INIT = 32'hBB67AE85
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rngStrobes_t              strb,
  input  logic [$clog2(WORDS)-1:0] stepIdx,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOutEn
);

  localparam int ADDR_W = $clog2(WORDS);
  localparam int HALVES = DATA_W / WORD_W;
  localparam int LOADS  = WORDS / HALVES;
  localparam int LPTR_W = (LOADS > 1) ? $clog2(LOADS) : 1;

  logic [WORD_W-1:0] mem [WORDS];
  logic [LPTR_W-1:0] loadPtr;

  logic [WORD_W-1:0] aReg, bReg;
  logic              s1Valid;
  logic [ADDR_W-1:0] s1Idx;
  logic [WORD_W-1:0] s1A;
  logic [WORD_W-1:0] s1Next;
  logic              rdSel;

  logic [ADDR_W-1:0] nextIdx;
  logic [WORD_W-1:0] aRot;
  logic [WORD_W-1:0] aStep;
  logic [WORD_W-1:0] bStep;
  logic [WORD_W-1:0] mixWord;
  logic [DATA_W-1:0] chunk0, chunk1;

  assign nextIdx = (stepIdx == ADDR_W'(WORDS - 1)) ? '0 : stepIdx + ADDR_W'(1);
  assign aRot    = {aReg[WORD_W-1-ROT:0], aReg[WORD_W-1:WORD_W-ROT]};
  assign aStep   = aReg + aRot + mem[stepIdx];
  assign bStep   = bReg + s1A + s1Next;
  assign mixWord = s1A ^ bStep;

  assign chunk0 = DATA_W'({aReg, bReg});
  assign chunk1 = DATA_W'({aReg ^ bReg, aReg + bReg});

  // Seed array: host writes while idle, stage two writes during a run
  always_ff @(posedge clk) begin
    if (strb.loadWr) begin
      for (int h = 0; h < HALVES; h++) begin
        mem[ADDR_W'(int'(loadPtr) * HALVES + h)] <= dataIn[h*WORD_W +: WORD_W];
      end
    end else if (strb.beat && s1Valid) begin
      mem[s1Idx] <= mixWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPtr   <= '0;
      aReg      <= '0;
      bReg      <= '0;
      s1Valid   <= 1'b0;
      s1Idx     <= '0;
      s1A       <= '0;
      s1Next    <= '0;
      rdSel     <= 1'b0;
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else begin
      dataOutEn <= strb.rdTake;
      if (strb.loadWr) begin
        loadPtr <= loadPtr + LPTR_W'(1);
      end
      if (strb.runInit) begin
        loadPtr <= '0;
        aReg    <= A_INIT;
        bReg    <= B_INIT;
        s1Valid <= 1'b0;
        rdSel   <= 1'b0;
      end
      if (strb.beat) begin
        if (strb.issue) begin
          aReg    <= aStep;
          s1A     <= aStep;
          s1Next  <= mem[nextIdx];
          s1Idx   <= stepIdx;
          s1Valid <= 1'b1;
        end else begin
          s1Valid <= 1'b0;
        end
        if (s1Valid) begin
          bReg <= bStep;
        end
      end
      if (strb.rdTake) begin
        dataOut <= rdSel ? chunk1 : chunk0;
        rdSel   <= ~rdSel;
      end
    end
  end

endmodule

// File: rtl/seeded_mixer_rng.sv
module seeded_mixer_rng
  import rng_pkg::*;
#(
  parameter int                ITERS        = 256,
  parameter int                STAGE_CYCLES = 5,
  parameter int                WORDS        = 32,
  parameter int                WORD_W       = 32,
  parameter int                DATA_W       = 64,
  parameter int                ROT          = 13,
  parameter logic [WORD_W-1:0] A_INIT       = 32'h6A09E667,
  parameter logic [WORD_W-1:0] B_INIT       = 32'hBB67AE85
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              genReq,
  input  logic              rdReq,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              ready,
  output logic              done
);

  localparam int ADDR_W = $clog2(WORDS);

  rngStrobes_t       strb;
  logic [ADDR_W-1:0] stepIdx;

  rng_ctrl #(
    .ITERS(ITERS),
    .STAGE_CYCLES(STAGE_CYCLES),
    .WORDS(WORDS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .genReq(genReq),
    .rdReq(rdReq),
    .wrStrobe(wrStrobe),
    .ready(ready),
    .done(done),
    .strb(strb),
    .stepIdx(stepIdx)
  );

  rng_datapath #(
    .WORDS(WORDS),
    .WORD_W(WORD_W),
    .DATA_W(DATA_W),
    .ROT(ROT),
    .A_INIT(A_INIT),
    .B_INIT(B_INIT)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .stepIdx(stepIdx),
    .dataIn(dataIn),
    .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

endmodule

// File: rtl/seeded_mixer_rng_chk.sv
module seeded_mixer_rng_chk #(
  parameter int ITERS        = 256,
  parameter int STAGE_CYCLES = 5
) (
  input logic clk,
  input logic rstN,
  input logic genReq,
  input logic ready,
  input logic done,
  input logic dataOutEn
);

  localparam int RUN_CYCLES = STAGE_CYCLES * (ITERS + 1);

  logic        genSeen;
  logic [31:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genSeen <= 1'b0;
      busyCnt <= '0;
    end else begin
      genSeen <= genReq;
      busyCnt <= ready ? 32'd0 : busyCnt + 32'd1;
    end
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && genReq && !genSeen) |=> !ready); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !(genReq && !genSeen)) |=> ready); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ready); // R4
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ready); // R4
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 32'(RUN_CYCLES))); // R4
  AST_OUT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> ready); // R7

endmodule

bind seeded_mixer_rng seeded_mixer_rng_chk #(
  .ITERS(ITERS),
  .STAGE_CYCLES(STAGE_CYCLES)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .genReq(genReq),
  .ready(ready),
  .done(done),
  .dataOutEn(dataOutEn)
);

// File: tb/seeded_mixer_rng_tb.sv
module seeded_mixer_rng_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int ITERS        = 256;
  localparam int STAGE_CYCLES = 5;
  localparam int WORDS        = 32;
  localparam int LOADS        = 16;
  localparam int RUN_CYCLES   = STAGE_CYCLES * (ITERS + 1);
  localparam logic [31:0] A_START = 32'h6A09E667;
  localparam logic [31:0] B_START = 32'hBB67AE85;

  typedef struct packed {
    logic [63:0] base;   // seed pattern
    logic [4:0]  junk;   // transfers written before the seed
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{base: 64'h0000_0000_0000_0000, junk: 5'd0},
    '{base: 64'hFFFF_FFFF_FFFF_FFFF, junk: 5'd16},
    '{base: 64'h0123_4567_89AB_CDEF, junk: 5'd3},
    '{base: 64'h8000_0000_0000_0001, junk: 5'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        genReq = 1'b0;
  logic        rdReq = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] dataOut;
  logic        dataOutEn;
  logic        ready;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cnt;
  int mdlPtr = 0;
  logic [31:0] mdl [WORDS];
  logic [31:0] expA, expB, firstA, firstB;

  always #(CLK_PERIOD/2) clk = ~clk;

  seeded_mixer_rng u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .genReq(genReq),
    .rdReq(rdReq), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .ready(ready), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl13(input logic [31:0] v);
    return {v[18:0], v[31:19]};
  endfunction

  function automatic logic [63:0] seedChunk(input logic [63:0] base, input int k);
    return base ^ (64'(k + 1) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // Software model of the mixing run over the mirrored array
  task automatic modelRun();
    logic [31:0] a, b;
    int i;
    a = A_START;
    b = B_START;
    for (int s = 0; s < ITERS; s++) begin
      i = s % WORDS;
      a = a + rotl13(a) + mdl[i];
      b = b + a + mdl[(i + 1) % WORDS];
      mdl[i] = a ^ b;
    end
    expA = a;
    expB = b;
  endtask

  task automatic pushChunk(input logic [63:0] w);
    @(negedge clk);
    dataIn   = w;
    wrStrobe = 1'b1;
    mdl[2*mdlPtr]   = w[31:0];
    mdl[2*mdlPtr+1] = w[63:32];
    mdlPtr = (mdlPtr + 1) % LOADS;
  endtask

  task automatic endLoad();
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; genReq = 1'b0; rdReq = 1'b0; wrStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mdlPtr = 0;
  endtask

  task automatic runAndCheck();
    @(negedge clk) genReq = 1'b1;
    @(negedge clk) genReq = 1'b0;
    mdlPtr = 0;
    check(ready == 1'b0, "R3", "ready after start", 64'(ready), 64'd0);
    cnt = 0;
    while (!done && cnt < RUN_CYCLES + 50) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == RUN_CYCLES, "R4", "cycles to done", 64'(cnt), 64'(RUN_CYCLES));
    @(negedge clk);
    check(done == 1'b0 && ready == 1'b1, "R4", "done/ready after pulse",
          {62'd0, done, ready}, 64'd1);
  endtask

  task automatic readCheck(input logic [63:0] exp, input string req);
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
    check(dataOutEn == 1'b1, req, "dataOutEn on read", 64'(dataOutEn), 64'd1);
    check(dataOut == exp, req, "result chunk", dataOut, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && done == 1'b0 && dataOutEn == 1'b0, "R1",
          "state in reset", {61'd0, ready, done, dataOutEn}, 64'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && done == 1'b0 && dataOutEn == 1'b0, "R1",
          "state after reset", {61'd0, ready, done, dataOutEn}, 64'h4);

    // R7: read before any completed run is ignored
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
    check(dataOutEn == 1'b0, "R7", "read before run", 64'(dataOutEn), 64'd0);

    // R2: partial load, then reset puts the pointer back to 0
    for (int k = 0; k < 5; k++) pushChunk(64'hDEAD_0000_BEEF_0000 | 64'(k));
    endLoad();
    doReset();

    // Table walk: R2 pointer offsets and wrap, R5 mixing, R6 chunk order
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < int'(VECS[v].junk); k++)
        pushChunk(64'hA5A5_0000_5A5A_0000 | 64'(k));
      for (int k = 0; k < LOADS; k++) pushChunk(seedChunk(VECS[v].base, k));
      endLoad();
      modelRun();
      if (v == 0) begin
        firstA = expA;
        firstB = expB;
      end
      runAndCheck();
      readCheck({expA, expB}, (VECS[v].junk != 0) ? "R2" : "R5");
      readCheck({expA ^ expB, expA + expB}, "R6");
      readCheck({expA, expB}, "R6");
    end

    // R8: writes, reads and start edges during a run; genReq held high
    for (int k = 0; k < LOADS; k++) pushChunk(seedChunk(64'h1357_9BDF_2468_ACE0, k));
    endLoad();
    modelRun();
    @(negedge clk) genReq = 1'b1;
    @(negedge clk);
    mdlPtr = 0;
    check(ready == 1'b0, "R3", "ready after held start", 64'(ready), 64'd0);
    cnt = 0;
    repeat (20) begin @(negedge clk); cnt++; end
    wrStrobe = 1'b1; rdReq = 1'b1; dataIn = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    cnt++;
    wrStrobe = 1'b0; rdReq = 1'b0;
    check(dataOutEn == 1'b0, "R7", "read while busy", 64'(dataOutEn), 64'd0);
    genReq = 1'b0;
    @(negedge clk) begin cnt++; genReq = 1'b1; end
    while (!done && cnt < RUN_CYCLES + 50) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == RUN_CYCLES, "R8", "run not restarted", 64'(cnt), 64'(RUN_CYCLES));
    repeat (3) begin
      @(negedge clk);
      check(ready == 1'b1, "R3", "held genReq no restart", 64'(ready), 64'd1);
    end
    genReq = 1'b0;
    readCheck({expA, expB}, "R8");
    readCheck({expA ^ expB, expA + expB}, "R8");

    // R9: reset keeps the array; rerun continues from mixed contents
    doReset();
    check(ready == 1'b1 && dataOutEn == 1'b0, "R1", "after second reset",
          {62'd0, ready, dataOutEn}, 64'h2);
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
    check(dataOutEn == 1'b0, "R7", "read after reset", 64'(dataOutEn), 64'd0);
    modelRun();
    runAndCheck();
    readCheck({expA, expB}, "R9");

    // R10: same seed again gives the same result
    for (int k = 0; k < LOADS; k++) pushChunk(seedChunk(VECS[0].base, k));
    endLoad();
    runAndCheck();
    readCheck({firstA, firstB}, "R10");
    readCheck({firstA ^ firstB, firstA + firstB}, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule